// File: doc/BRIEF.md
# Ternary Bitwise Lookup Unit

This unit evaluates an arbitrary three-input boolean function on every bit position of a word. The function is given as an 8-entry truth table (`tt`). For each bit the three input bits form a 3-bit index, and the result is the truth-table entry at that index. The old destination value is always one of the inputs. Any function of two registers and the current destination can therefore be produced in one operation, and the result replaces the destination.

There are two modes. In wide mode the function is applied to all `DATA_W` bits at once. In slice mode a narrow lane of 8 or 16 bits is taken from each of the two source operands and from the old destination, each at its own indexed offset. The computed lane is written back at a fourth indexed offset, and every other destination bit is preserved. The result is registered and marked by a one-cycle valid strobe.

Top module: `bitlut3_unit`

## Requirements
- R1: The result bit is `tt[{c,b,a}]`, where `a` has weight 1, `b` has weight 2 and `c` has weight 4. Bit 0 of `tt` is its least significant bit. Consequently `tt`=0x00 gives all zeros and `tt`=0xFF gives all ones.
- R2: Wide mode is selected by `mode`=0. For each bit i of the word, `a`=`opb[i]`, `b`=`opa[i]` and `c`=`dst_old[i]`.
- R3: In wide mode, `tt`=0xF0 returns `dst_old` unchanged.
- R4: Slice mode is selected by `mode`=1. The lane size is 8 bits when `wide_sel`=0 and 16 bits when `wide_sel`=1. No more than the lane size of bits is ever written.
- R5: Each lane offset is index × lane size, clamped to at most `DATA_W`. In slice mode, lane bit j takes `a` from `opa[off(sel_a)+j]`, `b` from `opb[off(sel_b)+j]` and `c` from `dst_old[off(sel_c)+j]`, and its result is written to bit `off(sel_d)+j`.
- R6: In slice mode, every destination bit outside the written lane equals its `dst_old` value.
- R7: A source position at or beyond `DATA_W` reads as 0. A destination position at or beyond `DATA_W` is not written. When `off(sel_d)` ≥ `DATA_W`, the result equals `dst_old`.
- R8: `dst_new` and `out_valid` are 0 after reset. An accepted input (`in_valid`=1) appears on `dst_new` on the following clock edge, with `out_valid`=1. While `in_valid`=0, `out_valid` falls and `dst_new` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| mode | input | 1 | 0 = wide, 1 = slice |
| wide_sel | input | 1 | Slice lane size: 0 = 8 bits, 1 = 16 bits |
| tt | input | 8 | Truth table of the function |
| opa | input | DATA_W | First source operand |
| opb | input | DATA_W | Second source operand |
| dst_old | input | DATA_W | Current destination value |
| sel_a | input | IDX_W | Lane index into `opa` |
| sel_b | input | IDX_W | Lane index into `opb` |
| sel_c | input | IDX_W | Lane index into `dst_old` as a source |
| sel_d | input | IDX_W | Lane index of the written destination lane |
| out_valid | output | 1 | Result valid strobe |
| dst_new | output | DATA_W | New destination value |

## Verification
The following behaviours are checked by assertions on every clock:
- the valid latency and the hold while idle;
- constant and pass-through truth tables in wide mode;
- preservation of every destination bit outside the written lane;
- the out-of-range destination case.

Other behaviours appear only in the bench's scenarios, which compare against a behavioural reference:
- the operand-to-weight binding;
- the lane offsets of each source;
- zero fill from out-of-range source lanes;
- the exact lane contents for arbitrary functions.

// File: rtl/bitlut3_pkg.sv
package bitlut3_pkg;

   typedef enum logic {
      LUT_WIDE  = 1'b0,
      LUT_SLICE = 1'b1
   } lut_mode_e;

   // truth-table pick: a weight 1, b weight 2, c weight 4
   function automatic logic lut3_pick(input logic [7:0] table_v,
                                      input logic a, input logic b, input logic c);
      return table_v[{c, b, a}];
   endfunction

endpackage

// File: rtl/bitlut3_wide.sv
module bitlut3_wide #(
   parameter int DATA_W = 64
) (
   input  logic [7:0]        tt,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] dst_old,
   output logic [DATA_W-1:0] res
);
   import bitlut3_pkg::*;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      assign res[g] = lut3_pick(tt, opb[g], opa[g], dst_old[g]);
   end

endmodule

// File: rtl/bitlut3_offset.sv
module bitlut3_offset #(
   parameter int DATA_W    = 64,
   parameter int IDX_W     = 4,
   parameter int NARROW_SZ = 8,
   parameter int WIDE_SZ   = 16,
   parameter int OFF_W     = 10
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             wide_sel,
   output logic [OFF_W-1:0] off
);
   localparam logic [OFF_W-1:0] LIMIT = OFF_W'(DATA_W);

   logic [OFF_W-1:0] raw;

   always_comb begin
      raw = OFF_W'(idx) * (wide_sel ? OFF_W'(WIDE_SZ) : OFF_W'(NARROW_SZ));
      off = (raw > LIMIT) ? LIMIT : raw;
   end

endmodule

// File: rtl/bitlut3_slice.sv
module bitlut3_slice #(
   parameter int DATA_W    = 64,
   parameter int IDX_W     = 4,
   parameter int NARROW_SZ = 8,
   parameter int WIDE_SZ   = 16
) (
   input  logic [7:0]        tt,
   input  logic              wide_sel,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] dst_old,
   input  logic [IDX_W-1:0]  sel_a,
   input  logic [IDX_W-1:0]  sel_b,
   input  logic [IDX_W-1:0]  sel_c,
   input  logic [IDX_W-1:0]  sel_d,
   output logic [DATA_W-1:0] res
);
   import bitlut3_pkg::*;

   localparam int PW    = $clog2(DATA_W);
   localparam int SZL_W = $clog2(WIDE_SZ);
   localparam int RAW_W = IDX_W + SZL_W + 1;
   localparam int LIM_W = $clog2(DATA_W + 1);
   localparam int OFF_W = ((RAW_W > LIM_W) ? RAW_W : LIM_W) + 1;
   localparam int NPORT = 4;

   logic [NPORT-1:0][IDX_W-1:0] idx_all;
   logic [NPORT-1:0][OFF_W-1:0] off_all;
   logic [WIDE_SZ-1:0]          lane;
   logic [OFF_W-1:0]            lane_len;

   assign idx_all  = {sel_d, sel_c, sel_b, sel_a};
   assign lane_len = wide_sel ? OFF_W'(WIDE_SZ) : OFF_W'(NARROW_SZ);

   for (genvar k = 0; k < NPORT; k++) begin : g_off
      bitlut3_offset #(
         .DATA_W(DATA_W), .IDX_W(IDX_W), .NARROW_SZ(NARROW_SZ),
         .WIDE_SZ(WIDE_SZ), .OFF_W(OFF_W)
      ) u_off (
         .idx(idx_all[k]), .wide_sel(wide_sel), .off(off_all[k])
      );
   end

   // gather each lane bit from the three sources, zero beyond the word
   for (genvar j = 0; j < WIDE_SZ; j++) begin : g_lane
      logic [OFF_W-1:0] pos_a, pos_b, pos_c;
      logic             bit_a, bit_b, bit_c;
      assign pos_a = off_all[0] + OFF_W'(j);
      assign pos_b = off_all[1] + OFF_W'(j);
      assign pos_c = off_all[2] + OFF_W'(j);
      assign bit_a = (pos_a < OFF_W'(DATA_W)) ? opa[pos_a[PW-1:0]]     : 1'b0;
      assign bit_b = (pos_b < OFF_W'(DATA_W)) ? opb[pos_b[PW-1:0]]     : 1'b0;
      assign bit_c = (pos_c < OFF_W'(DATA_W)) ? dst_old[pos_c[PW-1:0]] : 1'b0;
      assign lane[j] = lut3_pick(tt, bit_a, bit_b, bit_c);
   end

   // merge the lane into the old destination
   always_comb begin
      res = dst_old;
      for (int i = 0; i < DATA_W; i++) begin
         logic [OFF_W-1:0] here;
         logic [OFF_W-1:0] rel;
         here = OFF_W'(i);
         rel  = here - off_all[3];
         if (here >= off_all[3] && rel < lane_len)
            res[i] = lane[rel[SZL_W-1:0]];
      end
   end

endmodule

// File: rtl/bitlut3_unit.sv
module bitlut3_unit #(
   parameter int DATA_W    = 64,
   parameter int IDX_W     = 4,
   parameter int NARROW_SZ = 8,
   parameter int WIDE_SZ   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              mode,
   input  logic              wide_sel,
   input  logic [7:0]        tt,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] dst_old,
   input  logic [IDX_W-1:0]  sel_a,
   input  logic [IDX_W-1:0]  sel_b,
   input  logic [IDX_W-1:0]  sel_c,
   input  logic [IDX_W-1:0]  sel_d,
   output logic              out_valid,
   output logic [DATA_W-1:0] dst_new
);
   import bitlut3_pkg::*;

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power of two");
   end
   if ((NARROW_SZ & (NARROW_SZ - 1)) != 0 || (WIDE_SZ & (WIDE_SZ - 1)) != 0) begin : g_bad_lane
      $error("lane sizes must be powers of two");
   end
   if (NARROW_SZ > WIDE_SZ || WIDE_SZ > DATA_W) begin : g_bad_order
      $error("lane sizes must satisfy NARROW_SZ <= WIDE_SZ <= DATA_W");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must be at least 1");
   end

   logic [DATA_W-1:0] wide_res;
   logic [DATA_W-1:0] slice_res;
   logic [DATA_W-1:0] next_val;

   bitlut3_wide #(.DATA_W(DATA_W)) u_wide (
      .tt(tt), .opa(opa), .opb(opb), .dst_old(dst_old), .res(wide_res)
   );

   bitlut3_slice #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .NARROW_SZ(NARROW_SZ), .WIDE_SZ(WIDE_SZ)
   ) u_slice (
      .tt(tt), .wide_sel(wide_sel), .opa(opa), .opb(opb), .dst_old(dst_old),
      .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_d(sel_d), .res(slice_res)
   );

   assign next_val = (lut_mode_e'(mode) == LUT_SLICE) ? slice_res : wide_res;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         dst_new   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) dst_new <= next_val;
      end
   end

endmodule

// File: rtl/bitlut3_chk.sv
module bitlut3_chk #(
   parameter int DATA_W    = 64,
   parameter int IDX_W     = 4,
   parameter int NARROW_SZ = 8,
   parameter int WIDE_SZ   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              mode,
   input logic              wide_sel,
   input logic [7:0]        tt,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [DATA_W-1:0] dst_old,
   input logic [IDX_W-1:0]  sel_a,
   input logic [IDX_W-1:0]  sel_b,
   input logic [IDX_W-1:0]  sel_c,
   input logic [IDX_W-1:0]  sel_d,
   input logic              out_valid,
   input logic [DATA_W-1:0] dst_new
);
   logic [2*DATA_W-1:0] win_ext;
   logic [DATA_W-1:0]   keep;
   int                  dst_off;
   logic                dst_oob;

   always_comb begin
      dst_off = int'(sel_d) * (wide_sel ? WIDE_SZ : NARROW_SZ);
      win_ext = ((2*DATA_W)'(1) << (wide_sel ? WIDE_SZ : NARROW_SZ)) - (2*DATA_W)'(1);
      win_ext = win_ext << dst_off;
      keep    = ~win_ext[DATA_W-1:0];
      dst_oob = dst_off >= DATA_W;
   end

   assert_valid_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(dst_new)));
   assert_zero_tt_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode && tt == 8'h00) |=> dst_new == '0);
   assert_ones_tt_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode && tt == 8'hFF) |=> dst_new == '1);
   assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode && tt == 8'hF0) |=> dst_new == $past(dst_old));
   assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode) |=> ((dst_new ^ $past(dst_old)) & $past(keep)) == '0);
   assert_oob_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode && dst_oob) |=> dst_new == $past(dst_old));

endmodule

bind bitlut3_unit bitlut3_chk #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .NARROW_SZ(NARROW_SZ), .WIDE_SZ(WIDE_SZ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .wide_sel(wide_sel),
   .tt(tt), .opa(opa), .opb(opb), .dst_old(dst_old), .sel_a(sel_a), .sel_b(sel_b),
   .sel_c(sel_c), .sel_d(sel_d), .out_valid(out_valid), .dst_new(dst_new)
);

// File: tb/bitlut3_unit_test.sv
`timescale 1ns/1ps
module bitlut3_unit_test;
   localparam int W = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, mode = 1'b0, wide_sel = 1'b0;
   logic [7:0]  tt = 8'h00;
   logic [W-1:0] opa = '0, opb = '0, dst_old = '0;
   logic [3:0]  sel_a = '0, sel_b = '0, sel_c = '0, sel_d = '0;
   logic        out_valid;
   logic [W-1:0] dst_new;

   int checks = 0, errors = 0;
   logic chk_en = 1'b0, done = 1'b0;
   string cur_tag = "R8", exp_tag = "R8";
   logic [W-1:0] exp_d = '0;
   logic exp_v = 1'b0;
   logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

   always #2.5 clk = ~clk;

   bitlut3_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .wide_sel(wide_sel),
      .tt(tt), .opa(opa), .opb(opb), .dst_old(dst_old), .sel_a(sel_a), .sel_b(sel_b),
      .sel_c(sel_c), .sel_d(sel_d), .out_valid(out_valid), .dst_new(dst_new)
   );

   function automatic logic [63:0] ref_f(logic m, logic w, logic [7:0] t,
         logic [63:0] a, logic [63:0] b, logic [63:0] d, int ia, int ib, int ic, int id);
      logic [63:0] r;
      int sz, oa, ob, oc, od;
      logic xa, xb, xc;
      r = d;
      if (!m) begin
         for (int i = 0; i < 64; i++) r[i] = t[{d[i], a[i], b[i]}];
      end else begin
         sz = w ? 16 : 8;
         oa = ia * sz; if (oa > 64) oa = 64;
         ob = ib * sz; if (ob > 64) ob = 64;
         oc = ic * sz; if (oc > 64) oc = 64;
         od = id * sz; if (od > 64) od = 64;
         for (int j = 0; j < sz; j++) begin
            xa = (oa + j < 64) ? a[oa + j] : 1'b0;
            xb = (ob + j < 64) ? b[ob + j] : 1'b0;
            xc = (oc + j < 64) ? d[oc + j] : 1'b0;
            if (od + j < 64) r[od + j] = t[{xc, xb, xa}];
         end
      end
      return r;
   endfunction

   function automatic logic [63:0] nxt(logic [63:0] s);
      logic [63:0] x;
      x = s ^ (s << 13);
      x = x ^ (x >> 7);
      return x ^ (x << 17);
   endfunction

   // reference model, one step per clock
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_v <= 1'b0;
         exp_d <= '0;
      end else begin
         exp_v <= in_valid;
         if (in_valid)
            exp_d <= ref_f(mode, wide_sel, tt, opa, opb, dst_old,
                           int'(sel_a), int'(sel_b), int'(sel_c), int'(sel_d));
         exp_tag <= cur_tag;
      end
   end

   always @(negedge clk) begin
      if (chk_en && !done) begin
         checks++;
         if (dst_new !== exp_d || out_valid !== exp_v) begin
            errors++;
            $display("FAIL %s: dst_new=%h valid=%b expected %h valid=%b",
                     exp_tag, dst_new, out_valid, exp_d, exp_v);
         end
      end
   end

   task automatic drive(logic v, logic m, logic w, logic [7:0] t,
                        logic [63:0] a, logic [63:0] b, logic [63:0] d,
                        logic [3:0] ia, logic [3:0] ib, logic [3:0] ic, logic [3:0] id,
                        string tag);
      @(negedge clk);
      in_valid = v; mode = m; wide_sel = w; tt = t;
      opa = a; opb = b; dst_old = d;
      sel_a = ia; sel_b = ib; sel_c = ic; sel_d = id;
      cur_tag = tag;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] tts [8];
      logic [63:0] a, b, d;
      tts = '{8'hF0, 8'h00, 8'hFF, 8'hE8, 8'h96, 8'hCA, 8'hAA, 8'hCC};
      repeat (3) @(negedge clk);
      // R8 reset state
      checks++;
      if (dst_new !== '0 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R8 reset: dst_new=%h valid=%b expected 0 0", dst_new, out_valid);
      end
      rst_n = 1'b1;
      chk_en = 1'b1;

      // R1 R2 R3: wide mode, several functions and patterns
      for (int p = 0; p < 4; p++) begin
         seed = nxt(seed); a = seed;
         seed = nxt(seed); b = seed;
         seed = nxt(seed); d = seed;
         if (p == 3) begin a = 64'hFFFF_0000_FFFF_0000; b = 64'hFF00_FF00_FF00_FF00; d = 64'hF0F0_F0F0_F0F0_F0F0; end
         for (int k = 0; k < 8; k++)
            drive(1'b1, 1'b0, 1'b0, tts[k], a, b, d, 4'd0, 4'd0, 4'd0, 4'd0,
                  (tts[k] == 8'hF0) ? "R3" : ((k < 3) ? "R1" : "R2"));
      end

      // R8 idle: output holds
      drive(1'b0, 1'b0, 1'b0, 8'h00, '0, '0, '0, 4'd0, 4'd0, 4'd0, 4'd0, "R8");
      drive(1'b0, 1'b1, 1'b1, 8'hFF, '1, '1, '1, 4'd1, 4'd1, 4'd1, 4'd1, "R8");

      // R4 R5 R6: slice mode, in-range indices
      for (int s = 0; s < 2; s++) begin
         for (int q = 0; q < 12; q++) begin
            logic [3:0] ia, ib, ic, id;
            int lim;
            lim = s ? 4 : 8;
            seed = nxt(seed); a = seed;
            seed = nxt(seed); b = seed;
            seed = nxt(seed); d = seed;
            ia = 4'((q * 3) % lim); ib = 4'((q * 5 + 1) % lim);
            ic = 4'((q + 2) % lim); id = 4'((q * 7 + 3) % lim);
            drive(1'b1, 1'b1, s[0], tts[q % 8] ^ 8'(q), a, b, d, ia, ib, ic, id,
                  (q % 3 == 0) ? "R4" : ((q % 3 == 1) ? "R5" : "R6"));
         end
      end

      // R7: out-of-range source lanes read zero, out-of-range destination untouched
      drive(1'b1, 1'b1, 1'b0, 8'hAA, '1, '1, '1, 4'd8, 4'd0, 4'd0, 4'd2, "R7");
      drive(1'b1, 1'b1, 1'b1, 8'hCC, '1, '1, '1, 4'd0, 4'd5, 4'd0, 4'd1, "R7");
      drive(1'b1, 1'b1, 1'b1, 8'hF0, '1, '1, 64'h0123_4567_89AB_CDEF, 4'd0, 4'd0, 4'd15, 4'd3, "R7");
      drive(1'b1, 1'b1, 1'b0, 8'hFF, '0, '0, 64'h0123_4567_89AB_CDEF, 4'd0, 4'd0, 4'd0, 4'd9, "R7");
      drive(1'b1, 1'b1, 1'b1, 8'h00, '1, '1, 64'hDEAD_BEEF_0BAD_F00D, 4'd0, 4'd0, 4'd0, 4'd4, "R7");
      // R4: 8-bit lane writes only 8 bits at the top lane
      drive(1'b1, 1'b1, 1'b0, 8'hFF, '0, '0, '0, 4'd0, 4'd0, 4'd0, 4'd7, "R4");
      drive(1'b1, 1'b1, 1'b1, 8'hFF, '0, '0, '0, 4'd0, 4'd0, 4'd0, 4'd3, "R4");
      drive(1'b0, 1'b0, 1'b0, 8'h00, '0, '0, '0, 4'd0, 4'd0, 4'd0, 4'd0, "R8");
      drive(1'b0, 1'b0, 1'b0, 8'h00, '0, '0, '0, 4'd0, 4'd0, 4'd0, 4'd0, "R8");
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule